// File: doc/BRIEF.md
# Callee-Save Procedure Call Sequencer

This block carries out one complex call instruction for a processor core. The core pulses `start` with the branch target, an argument count and a register save mask. The sequencer then builds the callee's frame on a downward-growing stack of 4-byte words.

It reads the live architectural state through one register-file read port and writes one word per cycle through a single memory write port. The first step rounds the stack pointer down to a word boundary. The pushes then go out in a fixed order:

1. the argument count;
2. each register chosen by the mask, in ascending register number;
3. the return address;
4. the frame pointer;
5. the argument pointer;
6. the status word, with its condition codes cleared.

Unselected registers cost no cycles. When the last word is written, a one-cycle `done` presents the new program counter, the new stack and frame pointers (both equal to the address of the status word) and the new argument pointer (the address of the pushed argument count). The core writes these values back and fetches from the target. Return handling, protection checks and faults during the sequence are outside this block.

Top module: `call_frame_seq`

## Requirements
- R1: While idle, the block reads read-port address 14 (stack pointer). On `start`, it takes that value with bits [1:0] cleared as the base of the frame.
- R2: Each push writes one 32-bit word at an address 4 below the previous push. The first push is the zero-extended argument count, written at base minus 4.
- R3: Every general register i (0 to 11) whose bit i is set in `save_mask` is read at read-port address i and pushed. These pushes come right after the argument count, in ascending i.
- R4: Unselected registers take no cycles. If `start` is sampled at clock edge 0 and N mask bits are set, the block makes exactly 5+N writes. `done` is high in the cycle that follows edge 5+N.
- R5: After the saved registers come three pushes, in this order: the return address (read-port address 15), the frame pointer (address 13) and the argument pointer (address 12).
- R6: The last push is the status word (read-port address 16), with its condition-code bits [3:0] forced to zero.
- R7: `done` is high for exactly one cycle. In that cycle:
  - `new_pc` equals the latched `call_target`;
  - `new_sp` and `new_fp` both equal the address of the status-word push;
  - `new_ap` equals the address of the argument-count push.
- R8: `busy` is high in every cycle from the one after `start` is sampled through the last push. It is low in the `done` cycle and while idle.
- R9: A `start` pulse while a sequence is in progress is ignored. It changes neither the write sequence nor the results, and does not begin a new sequence after `done`.
- R10: After reset the block is idle, with `busy`, `done` and `mem_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a call sequence (sampled while idle) |
| call_target | input | 32 | Address of the called procedure's first instruction |
| arg_count | input | 8 | Number of arguments to record in the frame |
| save_mask | input | 12 | One bit per general register 0 to 11 to be saved |
| rf_raddr | output | 5 | Register read address: 0-11 general, 12 arg ptr, 13 frame ptr, 14 stack ptr, 15 PC, 16 status |
| rf_rdata | input | 32 | Combinational read data for `rf_raddr` |
| mem_we | output | 1 | Memory write strobe, one word per cycle |
| mem_addr | output | 32 | Byte address of the pushed word |
| mem_wdata | output | 32 | Pushed word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| new_pc | output | 32 | Branch target, valid with `done` |
| new_sp | output | 32 | Updated stack pointer, valid with `done` |
| new_fp | output | 32 | Updated frame pointer, valid with `done` |
| new_ap | output | 32 | Updated argument pointer, valid with `done` |

## Verification
The assertions take for granted that `rf_rdata` follows `rf_raddr` combinationally within the same cycle. They also assume the register values stay constant while a sequence runs, since nothing else writes the register file during the call. The bench models the register file as a pure function of the address, with its contents changed only while the block is idle. It sweeps all 4096 save masks, with all four low-bit offsets of the stack pointer and nonzero condition codes in the status word. On some calls it pulses `start` again in the middle of the sequence.

// File: rtl/call_frame_seq.sv
`timescale 1ns/1ps
module call_frame_seq #(
  parameter int DW   = 32,
  parameter int NGR  = 12,
  parameter int ARGW = 8,
  parameter int CCW  = 4,
  localparam int RAW = $clog2(NGR + 5)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   call_target,
  input  logic [ARGW-1:0] arg_count,
  input  logic [NGR-1:0]  save_mask,
  output logic [RAW-1:0]  rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   new_pc,
  output logic [DW-1:0]   new_sp,
  output logic [DW-1:0]   new_fp,
  output logic [DW-1:0]   new_ap
);
  localparam logic [RAW-1:0] AP_IDX  = RAW'(NGR);
  localparam logic [RAW-1:0] FP_IDX  = RAW'(NGR + 1);
  localparam logic [RAW-1:0] SP_IDX  = RAW'(NGR + 2);
  localparam logic [RAW-1:0] PC_IDX  = RAW'(NGR + 3);
  localparam logic [RAW-1:0] PSW_IDX = RAW'(NGR + 4);
  localparam logic [DW-1:0]  WORD    = DW'(4);
  localparam logic [DW-1:0]  CC_MASK = DW'((1 << CCW) - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ARGC, S_REGS, S_RET, S_FP, S_AP, S_PSW, S_DONE
  } state_t;

  state_t          st;
  logic [DW-1:0]   sp, tgt, apn;
  logic [ARGW-1:0] argc;
  logic [NGR-1:0]  rem, low, rem_next;
  logic [RAW-1:0]  idx;

  assign low      = rem & (~rem + 1'b1);
  assign rem_next = rem & ~low;

  always_comb begin
    idx = '0;
    for (int i = NGR - 1; i >= 0; i--)
      if (rem[i]) idx = RAW'(i);
  end

  always_comb begin
    case (st)
      S_REGS:  rf_raddr = idx;
      S_RET:   rf_raddr = PC_IDX;
      S_FP:    rf_raddr = FP_IDX;
      S_AP:    rf_raddr = AP_IDX;
      S_PSW:   rf_raddr = PSW_IDX;
      default: rf_raddr = SP_IDX;
    endcase
  end

  assign mem_we    = st inside {S_ARGC, S_REGS, S_RET, S_FP, S_AP, S_PSW};
  assign mem_addr  = sp - WORD;
  assign mem_wdata = (st == S_ARGC) ? DW'(argc) :
                     (st == S_PSW)  ? (rf_rdata & ~CC_MASK) : rf_rdata;

  assign busy   = (st != S_IDLE) && (st != S_DONE);
  assign done   = (st == S_DONE);
  assign new_pc = tgt;
  assign new_sp = sp;
  assign new_fp = sp;
  assign new_ap = apn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sp   <= '0;
      tgt  <= '0;
      apn  <= '0;
      argc <= '0;
      rem  <= '0;
    end else begin
      if (mem_we) sp <= sp - WORD;
      case (st)
        S_IDLE: if (start) begin
          sp   <= rf_rdata & ~DW'(3);
          tgt  <= call_target;
          argc <= arg_count;
          rem  <= save_mask;
          st   <= S_ARGC;
        end
        S_ARGC: begin
          apn <= sp - WORD;
          st  <= (rem == '0) ? S_RET : S_REGS;
        end
        S_REGS: begin
          rem <= rem_next;
          if (rem_next == '0) st <= S_RET;
        end
        S_RET:   st <= S_FP;
        S_FP:    st <= S_AP;
        S_AP:    st <= S_PSW;
        S_PSW:   st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[1:0] == 2'b00);

  assert_push_descends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) - WORD);

  assert_cc_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && rf_raddr == PSW_IDX) |-> mem_wdata[CCW-1:0] == '0);

  assert_single_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !mem_we);

  assert_frame_equals_stack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_fp == new_sp && new_ap - new_sp >= DW'(16));

  assert_busy_covers_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we |-> busy) and (done |-> !busy));

endmodule

// File: tb/call_frame_seq_test.sv
`timescale 1ns/1ps
module call_frame_seq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [31:0] call_target = '0;
  logic [7:0]  arg_count = '0;
  logic [11:0] save_mask = '0;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        mem_we, busy, done;
  logic [31:0] mem_addr, mem_wdata, new_pc, new_sp, new_fp, new_ap;

  call_frame_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .call_target(call_target),
    .arg_count(arg_count), .save_mask(save_mask), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .new_pc(new_pc),
    .new_sp(new_sp), .new_fp(new_fp), .new_ap(new_ap)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  logic [31:0] regv [0:16];

  always_comb rf_rdata = (rf_raddr <= 5'd16) ? regv[rf_raddr] : 32'h0;

  logic [31:0] wa [0:31];
  logic [31:0] wd [0:31];
  int wn = 0;
  always @(negedge clk) if (mem_we) begin
    wa[wn % 32] = mem_addr;
    wd[wn % 32] = mem_wdata;
    wn++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_call(input logic [11:0] m, input int off, input bit mid);
    logic [31:0] e [0:17];
    logic [31:0] a0;
    int k, base, n;
    bit busyok;
    for (int i = 0; i < 12; i++) regv[i] = 32'hA500_0000 ^ (i << 16) ^ {20'h0, m};
    regv[12] = 32'h0AA0_0000 + m;
    regv[13] = 32'h0FF0_0000 + m;
    regv[14] = 32'h0004_0000 + (m << 8) + off;
    regv[15] = 32'h1234_0000 + m;
    regv[16] = 32'hC0DE_F005 | {20'h0, m};
    a0 = regv[14] & ~32'h3;
    e[0] = {24'h0, m[7:0] ^ 8'h3C};
    k = 1;
    for (int i = 0; i < 12; i++) if (m[i]) begin e[k] = regv[i]; k++; end
    e[k] = regv[15]; e[k+1] = regv[13]; e[k+2] = regv[12];
    e[k+3] = regv[16] & ~32'hF;
    k = k + 4;
    @(negedge clk);
    call_target = 32'h8000_0000 | {20'h0, m};
    arg_count   = m[7:0] ^ 8'h3C;
    save_mask   = m;
    start = 1;
    base = wn;
    @(negedge clk);
    start = 0;
    n = 1;
    busyok = busy;
    while (!done && n < 100) begin
      if (mid && (n == 3 || n == 4)) begin
        start = 1; call_target = 32'hDEAD_BEEF; save_mask = ~m;
      end else start = 0;
      @(negedge clk);
      n++;
      if (!done) busyok = busyok & busy;
    end
    start = 0;
    check(n == k + 1, "R4 done cycle", n, k + 1);
    check(wn - base == k, "R4 write count", wn - base, k);
    check(busyok, "R8 busy during sequence", {31'h0, busyok}, 32'h1);
    check(!busy, "R8 busy low at done", {31'h0, busy}, 32'h0);
    check(new_pc == 32'h8000_0000 + m, "R7 new_pc", new_pc, 32'h8000_0000 + m);
    check(new_sp == a0 - 4 * k, "R7 new_sp", new_sp, a0 - 4 * k);
    check(new_fp == a0 - 4 * k, "R7 new_fp", new_fp, a0 - 4 * k);
    check(new_ap == a0 - 4, "R7 new_ap", new_ap, a0 - 4);
    for (int j = 0; j < k; j++) begin
      string t;
      t = (j == 0) ? "R2 argc" : (j < k - 4) ? "R3 saved reg" : (j < k - 1) ? "R5 linkage" : "R6 status";
      check(wd[(base + j) % 32] == e[j], {t, " data"}, wd[(base + j) % 32], e[j]);
      check(wa[(base + j) % 32] == a0 - 4 * (j + 1), (j == 0) ? "R1 base address" : "R2 address",
            wa[(base + j) % 32], a0 - 4 * (j + 1));
    end
    @(negedge clk);
    check(!done, "R7 done one cycle", {31'h0, done}, 32'h0);
    @(negedge clk);
    check(!busy && !mem_we, mid ? "R9 no restart" : "R8 idle after done", {30'h0, busy, mem_we}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 17; i++) regv[i] = 32'h0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_we, "R10 reset state", {29'h0, busy, done, mem_we}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !mem_we, "R10 idle after reset", {29'h0, busy, done, mem_we}, 32'h0);
    for (int m = 0; m < 4096; m++)
      run_call(12'(m), m % 4, (m % 7) == 3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_990_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule